// File: doc/BRIEF.md
# Time-Multiplexed Eight-Port PHY Adapter

This block sits on the MAC side of a shared, time-division-multiplexed link to an eight-port PHY. The link runs on one clock supplied by the PHY. A frame is eight consecutive clocks. Each clock is a slot owned by one port, and the slots run in ascending port order. The PHY raises a sync marker in the slot that belongs to port 0. The adapter tracks that marker with its own slot counter. In each slot it drives the owning port's transmit nibble, transmit enable and force-half-duplex request onto the shared bus.

The receive side of the bus is skewed two slots ahead of transmit. Receive fields seen in slot s belong to port (s+2) mod 8. This lets a MAC react to received data within the same frame. The adapter routes each slot's receive nibble, data-valid, collision, carrier-sense and link bits to registered per-port outputs. It marks each update with a one-clock strobe.

Before the first sync marker after reset, the block stays quiet. A sync marker that arrives in an unexpected slot realigns the counter and raises a sticky error flag. The flag stays high until it is cleared.

Top module: `tdm_phy_adapter`

## Requirements
- R1: After the block is locked, the transmit bus in the cycle that follows a clock edge carries the fields of the port that owns the new slot. Slot 0 is the cycle in which `tdm_sync_i` is high. Each later cycle is the next port, and the order wraps from 7 back to 0.
- R2: A port's transmit inputs are sampled only at the clock edge that opens that port's slot. Changes at other times do not reach the bus until the port's next slot.
- R3: From reset until the first clock edge that sees `tdm_sync_i` high, `tdm_txd_o`, `tdm_txen_o`, `tdm_fhd_o` and `tdm_frm_o` are all 0.
- R4: Receive fields sampled at the edge that ends slot s, including the slot in which sync is high, are stored for port (s+2) mod 8. They stay there until that port's next slot. In `rx_nib_o`, port p takes bits [4p+3:4p]. The other per-port vectors use bit p.
- R5: `rx_stb_o` is one-hot or zero. Bit p is high for exactly the one cycle after port p's receive fields were captured.
- R6: Before lock, receive bus activity is ignored. All receive outputs and strobes stay 0.
- R7: A sync marker in any slot makes that cycle slot 0. The rotation restarts from it.
- R8: When a sync marker arrives after lock while the counter expects a slot other than 0, `sync_err_o` rises on the next cycle. It stays high while `sync_err_clr_i` is low. A sync marker in the expected slot does not set it.
- R9: `sync_err_clr_i` high at an edge clears `sync_err_o`. If a new misplaced sync arrives at that same edge, the flag stays set.
- R10: `tdm_frm_o` is high exactly in the cycles in which the transmit bus carries port 0 after lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PHY-supplied link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_nib_i | input | 32 | Per-port transmit nibbles, port p at [4p+3:4p] |
| tx_en_i | input | 8 | Per-port transmit enable |
| tx_fhd_i | input | 8 | Per-port force-half-duplex request |
| rx_nib_o | output | 32 | Per-port received nibbles |
| rx_dv_o | output | 8 | Per-port receive data-valid |
| rx_col_o | output | 8 | Per-port collision |
| rx_crs_o | output | 8 | Per-port carrier sense |
| rx_link_o | output | 8 | Per-port link status |
| rx_stb_o | output | 8 | One-clock per-port update strobe |
| tdm_sync_i | input | 1 | Frame sync marker from the PHY |
| tdm_rxd_i | input | 4 | Shared receive nibble |
| tdm_rxdv_i | input | 1 | Shared receive data-valid |
| tdm_col_i | input | 1 | Shared collision |
| tdm_crs_i | input | 1 | Shared carrier sense |
| tdm_link_i | input | 1 | Shared link status |
| tdm_txd_o | output | 4 | Shared transmit nibble |
| tdm_txen_o | output | 1 | Shared transmit enable |
| tdm_fhd_o | output | 1 | Shared force-half-duplex request |
| tdm_frm_o | output | 1 | High while the bus carries port 0 |
| sync_err_clr_i | input | 1 | Clears the sticky sync error |
| sync_err_o | output | 1 | Sticky misplaced-sync flag |

## Verification
The bench goes after the lock boundary first. It applies a noisy receive bus and non-zero transmit inputs before any sync. A design that drives or captures before lock would show enables or strobes there.

Transmit inputs change every cycle. A design that samples a port outside its own slot, or that is one slot off in its rotation, puts the wrong port's nibble on the bus. The bench also checks the two-slot receive skew, including the capture in the sync cycle itself. A wrong skew or a missed sync-slot capture routes data to the wrong port.

A misplaced sync must realign the rotation and set the sticky flag. A clear that lands together with a new misplaced sync must leave the flag set. A design that gives the clear priority, or that ignores the realignment, fails these checks.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             en;
    logic             fhd;
  } tx_slot_t;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             dv;
    logic             col;
    logic             crs;
    logic             link;
  } rx_slot_t;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int NPORTS = 8,
  localparam int SW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          err_clr_i,
  output logic [SW-1:0] cur_slot_o,
  output logic [SW-1:0] nxt_slot_o,
  output logic          active_o,
  output logic          sync_err_o
);
  logic [SW-1:0] cnt_q;
  logic          locked_q;
  logic          err_q;
  logic          bad_sync;

  // an observed sync always defines slot 0
  assign cur_slot_o = sync_i ? '0 : cnt_q;
  assign nxt_slot_o = (cur_slot_o == SW'(NPORTS - 1)) ? '0 : cur_slot_o + 1'b1;
  assign active_o   = locked_q | sync_i;
  assign bad_sync   = sync_i & locked_q & (cnt_q != '0);
  assign sync_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cnt_q    <= nxt_slot_o;
      locked_q <= locked_q | sync_i;
      err_q    <= bad_sync | (err_q & ~err_clr_i);  // set wins over clear
    end
  end

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !err_clr_i |=> err_q);
  a_r8_good_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i && locked_q && cnt_q == '0 && !err_q |=> !err_q);
  a_r7_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> cnt_q == SW'(1 % NPORTS));
  a_r6_lock_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
  import tdm_pkg::*;
#(
  parameter int NPORTS = 8,
  localparam int SW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  tx_slot_t [NPORTS-1:0]   tx_i,
  input  logic [SW-1:0]           nxt_slot_i,
  input  logic                    active_i,
  output tx_slot_t                bus_o,
  output logic                    frm_o
);
  tx_slot_t bus_q;
  logic     frm_q;

  // load the owner of the coming slot at the edge that opens it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= '0;
      frm_q <= 1'b0;
    end else begin
      bus_q <= active_i ? tx_i[nxt_slot_i] : '0;
      frm_q <= active_i && (nxt_slot_i == '0);
    end
  end

  assign bus_o = bus_q;
  assign frm_o = frm_q;

  a_r10_frm_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q |=> !frm_q);
  a_r3_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> bus_q == '0 && !frm_q);
endmodule

// File: rtl/tdm_rx_demux.sv
module tdm_rx_demux
  import tdm_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int SKEW   = 2,
  localparam int SW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  rx_slot_t                bus_i,
  input  logic [SW-1:0]           cur_slot_i,
  input  logic                    active_i,
  output rx_slot_t [NPORTS-1:0]   rx_o,
  output logic [NPORTS-1:0]       stb_o
);
  rx_slot_t [NPORTS-1:0] rx_q;
  logic [NPORTS-1:0]     stb_q;
  logic [NPORTS-1:0]     hit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    // slot whose receive data belongs to port p
    localparam int CAP = (p + NPORTS - (SKEW % NPORTS)) % NPORTS;
    assign hit[p] = active_i && (cur_slot_i == SW'(CAP));

    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit[p] |=> $stable(rx_q[p]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      stb_q <= '0;
    end else begin
      stb_q <= hit;
      for (int p = 0; p < NPORTS; p++)
        if (hit[p]) rx_q[p] <= bus_i;
    end
  end

  assign rx_o  = rx_q;
  assign stb_o = stb_q;

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q));
  a_r6_no_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> stb_q == '0);
endmodule

// File: rtl/tdm_phy_adapter.sv
module tdm_phy_adapter
  import tdm_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int SKEW   = 2,
  localparam int SW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPORTS*NIB_W-1:0] tx_nib_i,
  input  logic [NPORTS-1:0]       tx_en_i,
  input  logic [NPORTS-1:0]       tx_fhd_i,
  output logic [NPORTS*NIB_W-1:0] rx_nib_o,
  output logic [NPORTS-1:0]       rx_dv_o,
  output logic [NPORTS-1:0]       rx_col_o,
  output logic [NPORTS-1:0]       rx_crs_o,
  output logic [NPORTS-1:0]       rx_link_o,
  output logic [NPORTS-1:0]       rx_stb_o,
  input  logic                    tdm_sync_i,
  input  logic [NIB_W-1:0]        tdm_rxd_i,
  input  logic                    tdm_rxdv_i,
  input  logic                    tdm_col_i,
  input  logic                    tdm_crs_i,
  input  logic                    tdm_link_i,
  output logic [NIB_W-1:0]        tdm_txd_o,
  output logic                    tdm_txen_o,
  output logic                    tdm_fhd_o,
  output logic                    tdm_frm_o,
  input  logic                    sync_err_clr_i,
  output logic                    sync_err_o
);
  tx_slot_t [NPORTS-1:0] tx_vec;
  rx_slot_t [NPORTS-1:0] rx_vec;
  tx_slot_t              tx_bus;
  rx_slot_t              rx_bus;
  logic [SW-1:0]         cur_slot;
  logic [SW-1:0]         nxt_slot;
  logic                  active;

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    assign tx_vec[p].nib = tx_nib_i[p*NIB_W +: NIB_W];
    assign tx_vec[p].en  = tx_en_i[p];
    assign tx_vec[p].fhd = tx_fhd_i[p];
    assign rx_nib_o[p*NIB_W +: NIB_W] = rx_vec[p].nib;
    assign rx_dv_o[p]   = rx_vec[p].dv;
    assign rx_col_o[p]  = rx_vec[p].col;
    assign rx_crs_o[p]  = rx_vec[p].crs;
    assign rx_link_o[p] = rx_vec[p].link;
  end

  assign rx_bus.nib  = tdm_rxd_i;
  assign rx_bus.dv   = tdm_rxdv_i;
  assign rx_bus.col  = tdm_col_i;
  assign rx_bus.crs  = tdm_crs_i;
  assign rx_bus.link = tdm_link_i;

  tdm_slot_timer #(.NPORTS(NPORTS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (tdm_sync_i),
    .err_clr_i  (sync_err_clr_i),
    .cur_slot_o (cur_slot),
    .nxt_slot_o (nxt_slot),
    .active_o   (active),
    .sync_err_o (sync_err_o)
  );

  tdm_tx_mux #(.NPORTS(NPORTS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_i       (tx_vec),
    .nxt_slot_i (nxt_slot),
    .active_i   (active),
    .bus_o      (tx_bus),
    .frm_o      (tdm_frm_o)
  );

  tdm_rx_demux #(.NPORTS(NPORTS), .SKEW(SKEW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_i      (rx_bus),
    .cur_slot_i (cur_slot),
    .active_i   (active),
    .rx_o       (rx_vec),
    .stb_o      (rx_stb_o)
  );

  assign tdm_txd_o  = tx_bus.nib;
  assign tdm_txen_o = tx_bus.en;
  assign tdm_fhd_o  = tx_bus.fhd;

  a_r1_frm_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdm_frm_o |-> $past(active));
  a_r3_no_txen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !tdm_txen_o && !tdm_fhd_o);
endmodule

// File: tb/tdm_phy_adapter_test.sv
module tdm_phy_adapter_test;
  localparam int NP = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP*4-1:0] tx_nib_i = '0;
  logic [NP-1:0] tx_en_i = '0, tx_fhd_i = '0;
  logic [NP*4-1:0] rx_nib_o;
  logic [NP-1:0] rx_dv_o, rx_col_o, rx_crs_o, rx_link_o, rx_stb_o;
  logic tdm_sync_i = 1'b0;
  logic [3:0] tdm_rxd_i = '0;
  logic tdm_rxdv_i = 1'b0, tdm_col_i = 1'b0, tdm_crs_i = 1'b0, tdm_link_i = 1'b0;
  logic [3:0] tdm_txd_o;
  logic tdm_txen_o, tdm_fhd_o, tdm_frm_o;
  logic sync_err_clr_i = 1'b0;
  logic sync_err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  tdm_phy_adapter uut (.*);

  typedef struct {
    logic [6:0] tx;    // {nib, en, fhd, frm}
    logic [7:0] stb;
    int         port;
    logic [7:0] rx;    // {nib, dv, col, crs, link}
    logic       err;
    logic       act;
  } exp_t;

  exp_t q[$];
  int   dcnt = 0;
  bit   locked_m = 0;
  bit   err_m = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare the previous expectation, then drive and predict one slot
  task automatic slot(input bit sync_b, input bit clr_b);
    exp_t e;
    logic [6:0] act_tx;
    logic [7:0] act_rx;
    int cur, nxt;
    @(negedge clk_i);
    if (q.size() > 0) begin
      e = q.pop_front();
      act_tx = {tdm_txd_o, tdm_txen_o, tdm_fhd_o, tdm_frm_o};
      if (e.act) check(act_tx == e.tx, "R1,R2,R10", 32'(act_tx), 32'(e.tx));
      else       check(act_tx == e.tx, "R3", 32'(act_tx), 32'(e.tx));
      if (e.act) check(rx_stb_o == e.stb, "R5", 32'(rx_stb_o), 32'(e.stb));
      else       check(rx_stb_o == e.stb, "R6", 32'(rx_stb_o), 32'(e.stb));
      if (e.stb != 0) begin
        act_rx = {rx_nib_o[e.port*4 +: 4], rx_dv_o[e.port], rx_col_o[e.port],
                  rx_crs_o[e.port], rx_link_o[e.port]};
        check(act_rx == e.rx, "R4", 32'(act_rx), 32'(e.rx));
      end
      if (!e.act) check({rx_nib_o, rx_dv_o, rx_col_o, rx_crs_o, rx_link_o} == '0, "R6",
                        32'(rx_nib_o), 32'h0);
      check(sync_err_o == e.err, "R8,R9", 32'(sync_err_o), 32'(e.err));
    end
    tdm_sync_i     = sync_b;
    sync_err_clr_i = clr_b;
    tx_nib_i = $urandom; tx_en_i = 8'($urandom); tx_fhd_i = 8'($urandom);
    {tdm_rxd_i, tdm_rxdv_i, tdm_col_i, tdm_crs_i, tdm_link_i} = 8'($urandom);
    // R7: a sync cycle is slot 0 of the design's rotation
    cur = sync_b ? 0 : dcnt;
    nxt = (cur + 1) % NP;
    e.act = locked_m || sync_b;
    if (e.act) begin
      e.tx   = {tx_nib_i[nxt*4 +: 4], tx_en_i[nxt], tx_fhd_i[nxt], nxt == 0};
      e.port = (cur + 2) % NP;
      e.stb  = 8'(1) << e.port;
      e.rx   = {tdm_rxd_i, tdm_rxdv_i, tdm_col_i, tdm_crs_i, tdm_link_i};
    end else begin
      e.tx = '0; e.port = 0; e.stb = '0; e.rx = '0;
    end
    err_m = (locked_m && sync_b && dcnt != 0) || (err_m && !clr_b);
    e.err = err_m;
    locked_m = locked_m || sync_b;
    dcnt = nxt;
    q.push_back(e);
  endtask

  task automatic frames(input int n);
    for (int f = 0; f < n; f++)
      for (int s = 0; s < NP; s++) slot(s == 0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tx_nib_i = '1; tx_en_i = '1; tx_fhd_i = '1;
    tdm_rxd_i = 4'hf; tdm_rxdv_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R3 reset state
    check({tdm_txd_o, tdm_txen_o, tdm_fhd_o, tdm_frm_o, rx_stb_o, sync_err_o} == '0,
          "R3", 32'({tdm_txd_o, tdm_txen_o, rx_stb_o}), 32'h0);
    rst_ni = 1'b1;
    // R6 pre-lock noise on all inputs
    for (int i = 0; i < 21; i++) slot(1'b0, 1'b0);
    frames(30);
    // R7/R8: misplaced sync in slot 5
    for (int s = 0; s < 5; s++) slot(s == 0, 1'b0);
    slot(1'b1, 1'b0);
    for (int s = 1; s < NP; s++) slot(1'b0, 1'b0);
    frames(4);
    // R9: plain clear mid-frame
    for (int s = 0; s < NP; s++) slot(s == 0, s == 3);
    frames(2);
    // R8 again, then clear colliding with another bad sync (set wins)
    for (int s = 0; s < 3; s++) slot(s == 0, 1'b0);
    slot(1'b1, 1'b0);
    for (int s = 1; s < 6; s++) slot(1'b0, 1'b0);
    slot(1'b1, 1'b1);
    for (int s = 1; s < NP; s++) slot(1'b0, 1'b0);
    for (int s = 0; s < NP; s++) slot(s == 0, s == 2);
    frames(20);
    slot(1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule